// File: doc/BRIEF.md
# Bus Device Instruction Decoder

This block turns a 16-bit instruction word into the control lines of a shared 16-bit data bus. Every device on the bus has a 5-bit identifier. For each instruction the decoder picks at most one device to drive the bus and at most one device to capture from it. Device identifiers go from 0 to 31. Identifier 0 is a null device: reading it leaves the bus undriven, so the pull-downs make it read as zero.

Three formats are recognised. An immediate store places a 10-bit constant on the bus. A move transfers a word from one device to another. An ALU operation tells the ALU which function to run and lets the ALU alone drive its result onto the bus. Any other encoding, including every branch-like pattern, is flagged as illegal. The instruction is held in a register that loads on a strobe from the sequencer. All outputs are combinational from that register and are gated by an execute strobe, so no enable can appear outside the execute phase.

Top module: `dbus_decoder`

## Requirements
- R1: After reset, and until the first instruction is loaded, every enable, `imm_drive`, `alu_oe` and `illegal` stays low, even while `exec_en` is high.
- R2: The instruction is captured from `instr_in` at the rising clock edge where `instr_load` is high. A change on `instr_in` without `instr_load` has no effect on any output.
- R3: While `exec_en` is low, `oe_vec`, `we_vec`, `imm_drive`, `alu_oe` and `illegal` are all zero, whatever instruction is held.
- R4: Bit 15 = 1 selects an immediate store. `imm_drive` is high and `imm_data` is bits 14..5 zero-extended to 16 bits. `we_vec` has only the bit indexed by bits 4..0 set, and `oe_vec` is zero.
- R5: Bits 15..10 = 010000 select a move. `oe_vec` has only the bit indexed by bits 9..5 set and `we_vec` has only the bit indexed by bits 4..0 set. Source and destination may be the same device.
- R6: Bits 15..10 = 001000 select an ALU operation. `alu_oe` is high, `alu_mode` is bit 9, `alu_func` is bits 8..5, `we_vec` has only the bit indexed by bits 4..0 set, and `oe_vec` is zero.
- R7: Bit 0 of `oe_vec` and bit 0 of `we_vec` are never set. A move from device 0 therefore leaves the bus with no driver.
- R8: Any encoding other than those in R4 to R6 raises `illegal` for the execute cycle, with every enable and driver low.
- R9: At most one bus driver is active at a time (`imm_drive`, `alu_oe` or one `oe_vec` bit), and each enable vector is one-hot or zero.
- R10: `imm_data` is zero unless an immediate store is executing. `alu_mode` and `alu_func` are zero unless an ALU operation is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_load | input | 1 | Capture `instr_in` at this edge |
| instr_in | input | 16 | Instruction word from fetch |
| exec_en | input | 1 | Execute-phase strobe qualifying all outputs |
| oe_vec | output | 32 | Per-device output enable, one-hot or zero |
| we_vec | output | 32 | Per-device write enable, one-hot or zero |
| imm_drive | output | 1 | Decoder drives `imm_data` onto the bus |
| imm_data | output | 16 | Zero-extended immediate value |
| alu_oe | output | 1 | ALU drives its result onto the bus |
| alu_mode | output | 1 | ALU logic/arithmetic select |
| alu_func | output | 4 | ALU function select |
| illegal | output | 1 | Unrecognised encoding during execute |

## Verification
A wrong held instruction or a misclassified format shows at the ports in the same execute cycle. It appears as a wrong bit in `oe_vec` or `we_vec`, a missing or spurious `illegal`, or two bus drivers at once. A bad capture path shows one instruction later, when stale enables repeat after a new word was loaded, or fresh enables appear without a load. Bus contention and a write to the null device are checked on every cycle, not only in the directed cases.

// File: rtl/dbus_decoder_pkg.sv
`timescale 1ns/1ps
package dbus_decoder_pkg;
  parameter int INSTR_W  = 16;
  parameter int DATA_W   = 16;
  parameter int DEV_ID_W = 5;
  parameter int IMM_W    = 10;
  parameter int FUNC_W   = 4;
  localparam int NUM_DEV = 1 << DEV_ID_W;
  localparam int OP_W    = INSTR_W - 2 * DEV_ID_W;

  localparam logic [OP_W-1:0] OP_MOVE = 6'b010000;
  localparam logic [OP_W-1:0] OP_ALU  = 6'b001000;

  typedef enum logic [1:0] {
    FMT_ILLEGAL = 2'd0,
    FMT_STORE   = 2'd1,
    FMT_MOVE    = 2'd2,
    FMT_ALU     = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [DEV_ID_W-1:0] src;
    logic [DEV_ID_W-1:0] dst;
    logic [IMM_W-1:0]    imm;
    logic                mode;
    logic [FUNC_W-1:0]   func;
  } fields_t;

  function automatic fmt_e classify(input logic [INSTR_W-1:0] w);
    if (w[INSTR_W-1])                                   return FMT_STORE;
    else if (w[INSTR_W-1 -: OP_W] == OP_MOVE)           return FMT_MOVE;
    else if (w[INSTR_W-1 -: OP_W] == OP_ALU)            return FMT_ALU;
    else                                                return FMT_ILLEGAL;
  endfunction

  function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/instr_hold.sv
`timescale 1ns/1ps
module instr_hold
  import dbus_decoder_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [INSTR_W-1:0] word_in,
  output logic [INSTR_W-1:0] word_q,
  output logic               valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      word_q  <= word_in;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/field_split.sv
`timescale 1ns/1ps
module field_split
  import dbus_decoder_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output fmt_e               fmt,
  output fields_t            flds
);
  always_comb begin
    fmt       = classify(word);
    flds.dst  = word[DEV_ID_W-1:0];
    flds.src  = word[2*DEV_ID_W-1:DEV_ID_W];
    flds.imm  = word[IMM_W+DEV_ID_W-1:DEV_ID_W];
    flds.func = word[FUNC_W+DEV_ID_W-1:DEV_ID_W];
    flds.mode = word[FUNC_W+DEV_ID_W];
  end
endmodule

// File: rtl/dev_onehot.sv
`timescale 1ns/1ps
module dev_onehot
  import dbus_decoder_pkg::*;
(
  input  logic                en,
  input  logic [DEV_ID_W-1:0] id,
  output logic [NUM_DEV-1:0]  vec
);
  genvar i;
  generate
    for (i = 0; i < NUM_DEV; i++) begin : g_dev
      if (i == 0) begin : g_null
        // null device never receives an enable
        assign vec[i] = 1'b0;
      end else begin : g_real
        assign vec[i] = en && (id == DEV_ID_W'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/dbus_decoder.sv
`timescale 1ns/1ps
module dbus_decoder
  import dbus_decoder_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_load,
  input  logic [15:0]  instr_in,
  input  logic         exec_en,
  output logic [31:0]  oe_vec,
  output logic [31:0]  we_vec,
  output logic         imm_drive,
  output logic [15:0]  imm_data,
  output logic         alu_oe,
  output logic         alu_mode,
  output logic [3:0]   alu_func,
  output logic         illegal
);
  logic [INSTR_W-1:0] ir_q;
  logic               ir_valid;
  fmt_e               dec_fmt;
  fields_t            flds;
  logic               run;
  logic               do_store, do_move, do_alu, do_write;
  logic [DEV_ID_W-1:0] wr_id;

  instr_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (instr_load),
    .word_in (instr_in),
    .word_q  (ir_q),
    .valid_q (ir_valid)
  );

  field_split u_split (
    .word (ir_q),
    .fmt  (dec_fmt),
    .flds (flds)
  );

  assign run      = exec_en && ir_valid;
  assign do_store = run && (dec_fmt == FMT_STORE);
  assign do_move  = run && (dec_fmt == FMT_MOVE);
  assign do_alu   = run && (dec_fmt == FMT_ALU);
  assign do_write = do_store || do_move || do_alu;
  assign wr_id    = flds.dst;

  dev_onehot u_oe (
    .en  (do_move),
    .id  (flds.src),
    .vec (oe_vec)
  );

  dev_onehot u_we (
    .en  (do_write),
    .id  (wr_id),
    .vec (we_vec)
  );

  always_comb begin
    imm_drive = do_store;
    imm_data  = do_store ? zext_imm(flds.imm) : '0;
    alu_oe    = do_alu;
    alu_mode  = do_alu && flds.mode;
    alu_func  = do_alu ? flds.func : '0;
    illegal   = run && (dec_fmt == FMT_ILLEGAL);
  end
endmodule

// File: rtl/dbus_decoder_chk.sv
`timescale 1ns/1ps
module dbus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_en,
  input logic        instr_load,
  input logic        ir_valid,
  input logic [31:0] oe_vec,
  input logic [31:0] we_vec,
  input logic        imm_drive,
  input logic        alu_oe,
  input logic        illegal
);
  // R3
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> (oe_vec == '0 && we_vec == '0 && !imm_drive && !alu_oe && !illegal));
  // R1
  no_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_valid |-> (we_vec == '0 && !illegal && !imm_drive && !alu_oe));
  // R7
  null_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_vec[0] && !we_vec[0]);
  // R9
  onehot_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_vec) && $onehot0(we_vec));
  // R9
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({imm_drive, alu_oe, |oe_vec}) <= 1);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (oe_vec == '0 && we_vec == '0 && !imm_drive && !alu_oe));
  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && $past(exec_en) && !$past(instr_load)) |->
      ($stable(oe_vec) && $stable(we_vec) && $stable(illegal)));
endmodule

bind dbus_decoder dbus_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_en    (exec_en),
  .instr_load (instr_load),
  .ir_valid   (ir_valid),
  .oe_vec     (oe_vec),
  .we_vec     (we_vec),
  .imm_drive  (imm_drive),
  .alu_oe     (alu_oe),
  .illegal    (illegal)
);

// File: tb/dbus_decoder_tb.sv
`timescale 1ns/1ps
module dbus_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_load = 1'b0;
  logic [15:0] instr_in = '0;
  logic        exec_en = 1'b0;
  logic [31:0] oe_vec, we_vec;
  logic        imm_drive, alu_oe, alu_mode, illegal;
  logic [15:0] imm_data;
  logic [3:0]  alu_func;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .instr_load(instr_load), .instr_in(instr_in),
    .exec_en(exec_en), .oe_vec(oe_vec), .we_vec(we_vec), .imm_drive(imm_drive),
    .imm_data(imm_data), .alu_oe(alu_oe), .alu_mode(alu_mode),
    .alu_func(alu_func), .illegal(illegal)
  );

  function automatic logic [31:0] sel(input logic [4:0] id);
    return (id == 5'd0) ? 32'h0 : (32'h1 << id);
  endfunction
  function automatic logic [15:0] mk_store(input logic [9:0] v, input logic [4:0] d);
    return {1'b1, v, d};
  endfunction
  function automatic logic [15:0] mk_move(input logic [4:0] s, input logic [4:0] d);
    return {6'b010000, s, d};
  endfunction
  function automatic logic [15:0] mk_alu(input logic m, input logic [3:0] f, input logic [4:0] d);
    return {6'b001000, m, f, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full output snapshot compare
  task automatic chk_all(input string req, input logic [31:0] e_oe, input logic [31:0] e_we,
                         input logic e_imm, input logic [15:0] e_data, input logic e_alu,
                         input logic e_mode, input logic [3:0] e_func, input logic e_ill);
    chk({req, " oe_vec"}, oe_vec, e_oe);
    chk({req, " we_vec"}, we_vec, e_we);
    chk({req, " imm_drive"}, {31'b0, imm_drive}, {31'b0, e_imm});
    chk({req, " imm_data"}, {16'b0, imm_data}, {16'b0, e_data});
    chk({req, " alu_oe"}, {31'b0, alu_oe}, {31'b0, e_alu});
    chk({req, " alu_mode"}, {31'b0, alu_mode}, {31'b0, e_mode});
    chk({req, " alu_func"}, {28'b0, alu_func}, {28'b0, e_func});
    chk({req, " illegal"}, {31'b0, illegal}, {31'b0, e_ill});
  endtask

  // load at one edge, open execute for the following cycle; sample mid-cycle
  task automatic load_exec(input logic [15:0] w);
    @(negedge clk); instr_in = w; instr_load = 1'b1; exec_en = 1'b0;
    @(negedge clk); instr_load = 1'b0; exec_en = 1'b1;
    #1;
  endtask

  task automatic end_exec();
    @(negedge clk); exec_en = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk_all("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1; exec_en = 1'b1; #1;
    chk_all("R1 exec before load", 0, 0, 0, 0, 0, 0, 0, 0);
    end_exec();
  endtask

  task automatic t_store();
    load_exec(mk_store(10'd1023, 5'd25));
    chk_all("R4 store max", 0, sel(5'd25), 1, 16'h03FF, 0, 0, 0, 0);
    end_exec();
    chk_all("R3 store idle", 0, 0, 0, 0, 0, 0, 0, 0);
    load_exec(mk_store(10'd2, 5'd1));
    chk_all("R4 store small", 0, sel(5'd1), 1, 16'h0002, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_store(10'd0, 5'd31));
    chk_all("R4 store zero", 0, sel(5'd31), 1, 16'h0000, 0, 0, 0, 0);
    end_exec();
  endtask

  task automatic t_move();
    load_exec(mk_move(5'd1, 5'd14));
    chk_all("R5 move", sel(5'd1), sel(5'd14), 0, 0, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_move(5'd7, 5'd7));
    chk_all("R5 move same dev", sel(5'd7), sel(5'd7), 0, 0, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_move(5'd31, 5'd16));
    chk_all("R5 move high", sel(5'd31), sel(5'd16), 0, 0, 0, 0, 0, 0);
    end_exec();
  endtask

  task automatic t_alu();
    load_exec(mk_alu(1'b0, 4'd1, 5'd14));
    chk_all("R6 alu logic", 0, sel(5'd14), 0, 0, 1, 0, 4'd1, 0);
    end_exec();
    load_exec(mk_alu(1'b1, 4'hF, 5'd3));
    chk_all("R6 alu arith", 0, sel(5'd3), 0, 0, 1, 1, 4'hF, 0);
    end_exec();
    chk_all("R10 alu idle", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_null();
    load_exec(mk_move(5'd0, 5'd2));
    chk_all("R7 move from null", 0, sel(5'd2), 0, 0, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_move(5'd4, 5'd0));
    chk_all("R7 move to null", sel(5'd4), 0, 0, 0, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_store(10'd5, 5'd0));
    chk_all("R7 store to null", 0, 0, 1, 16'h0005, 0, 0, 0, 0);
    end_exec();
  endtask

  task automatic t_illegal();
    logic [15:0] bad [5] = '{16'h0000, 16'h1234, 16'h6000, 16'h4421, 16'h2C41};
    for (int k = 0; k < 5; k++) begin
      load_exec(bad[k]);
      chk_all("R8 illegal", 0, 0, 0, 0, 0, 0, 0, 1);
      end_exec();
      chk({"R3 illegal idle"}, {31'b0, illegal}, 32'h0);
    end
  endtask

  task automatic t_hold();
    load_exec(mk_move(5'd9, 5'd10));
    end_exec();
    // change input without load, then execute again
    @(negedge clk); instr_in = mk_store(10'd77, 5'd20); exec_en = 1'b1; #1;
    chk_all("R2 no load keeps move", sel(5'd9), sel(5'd10), 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk_all("R2 held second cycle", sel(5'd9), sel(5'd10), 0, 0, 0, 0, 0, 0);
    end_exec();
    load_exec(mk_alu(1'b1, 4'd6, 5'd12));
    chk_all("R2 new load seen R9", 0, sel(5'd12), 0, 0, 1, 1, 4'd6, 0);
    end_exec();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #1;
    t_reset();
    t_store();
    t_move();
    t_alu();
    t_null();
    t_illegal();
    t_hold();
    done = 1;
    summary();
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule